// File: doc/BRIEF.md
# Background Page Reclaimer for a Tagless DRAM Cache

This block keeps a small reserve of unused DRAM-cache pages so that a page miss can always be given a frame without waiting. Every cache frame has an entry in an inverted table, indexed by frame number. The entry holds the page's backing physical page number, the address of the page-table entry that currently maps the page to the frame, and one bit for each TLB that holds a translation to the frame. Frames come from a free list. When a frame is handed out, the caller's physical page number and PTE address are written into the table, and the frame joins the tail of an age queue.

When the free count falls below a low mark, the engine starts reclaiming frames. It walks the age queue from the oldest entry. A frame that any TLB still holds is moved to the back of the queue and is not touched, so eviction never forces a TLB shootdown. For the first frame that no TLB holds, the engine locks its PTE by setting the busy flag. It then either issues a writeback, if the frame is dirty, or drops it. It rewrites the PTE to point at the physical page again, with the busy and in-cache flags cleared, and returns the frame to the free list. Reclaiming continues until the free count reaches a high mark. The table is never consulted on a cache hit; only allocation and reclaim touch it.

Top module: `evict_engine`

## Requirements
- R1: After reset the free count equals the number of frames (64), `alloc_ok` is 1, `no_victim`, `pte_req` and `wb_req` are 0, and successive allocations return frames 0, 1, 2, … in ascending order.
- R2: Every PTE access for an eviction uses the PTE address stored when the victim frame was allocated, and the writeback carries the physical page number stored at that allocation.
- R3: Reclaim starts only while the free count is below 2. Once started, it continues until the free count reaches 4 and then stops.
- R4: Among frames held by no TLB, victims are taken in allocation order, oldest first.
- R5: A frame whose TLB residence vector is non-zero, including a bit being set in the same cycle, is never chosen. When the scan meets such a frame, it moves the frame to the tail of the age queue.
- R6: PTE layout: bits [35:0] hold the page number, bit 36 is the in-cache flag, bit 37 is the bypass flag and bit 38 is the busy flag. An eviction first reads the PTE and then writes it back with bit 38 set and the other bits unchanged. After the data step it writes {busy=0, bypass unchanged, in-cache=0, stored physical page number}.
- R7: If the victim's `page_dirty` bit is 1, `wb_req` is raised after the lock write and held until `wb_done`, with no PTE access meanwhile. A clean victim instead gives a single-cycle `drop_pulse`. The unlock write follows in either case.
- R8: A frame re-enters the free list at the tail in the cycle its unlock write is acknowledged. An allocation never returns a frame that is still mapped, and the free count always equals the number of allocations and frees applied.
- R9: If a complete pass over the age queue finds only TLB-held frames, `no_victim` goes to 1 and the engine stays idle. A residence-clear event clears `no_victim` and restarts the scan.
- R10: `pte_req`, `pte_we` and `pte_addr` stay stable until `pte_ack`, and `wb_req` and `wb_page` stay stable until `wb_done`.
- R11: With the free count at 0, `alloc_ok` is 0 and an allocation request changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Take one frame from the free list |
| alloc_ppn | input | 36 | Physical page number recorded for the allocated frame |
| alloc_ptep | input | 42 | PTE address recorded for the allocated frame |
| alloc_ok | output | 1 | Free list not empty |
| alloc_page | output | 6 | Frame given by an allocation this cycle |
| res_set | input | 1 | A TLB took a translation to a frame |
| res_set_page | input | 6 | Frame for res_set |
| res_set_tlb | input | 2 | TLB index for res_set |
| res_clr | input | 1 | A TLB dropped a translation to a frame |
| res_clr_page | input | 6 | Frame for res_clr |
| res_clr_tlb | input | 2 | TLB index for res_clr |
| page_dirty | input | 64 | Per-frame dirty flags |
| pte_req | output | 1 | PTE memory request, held until acknowledge |
| pte_we | output | 1 | 1 for a PTE write, 0 for a read |
| pte_addr | output | 42 | PTE address |
| pte_wdata | output | 39 | PTE write data |
| pte_rdata | input | 39 | PTE read data, valid with pte_ack |
| pte_ack | input | 1 | PTE access done |
| wb_req | output | 1 | Writeback of a dirty frame, held until wb_done |
| wb_page | output | 6 | Frame to write back |
| wb_ppn | output | 36 | Destination physical page number |
| wb_done | input | 1 | Writeback finished |
| drop_pulse | output | 1 | Clean frame discarded |
| free_count | output | 7 | Number of free frames |
| no_victim | output | 1 | Last pass found every frame TLB-held |

## Verification
An allocation pop and the return of a reclaimed frame can hit the free list in the same cycle, because reclaiming runs while allocations continue. A random phase provokes this by allocating at about one cycle in three while acknowledge latencies vary. The bench judges each such cycle by comparing the free count with its own tally of pops and returns. It also checks that every popped frame is one its model holds as unmapped. A second pairing, a TLB fill to a frame arriving in the same cycle that frame is allocated, is exercised throughout, and the model's residence is checked against each lock read.

// File: rtl/evict_engine.sv
module evict_engine #(
  parameter int NPAGES  = 64,
  parameter int NTLB    = 4,
  parameter int PPN_W   = 36,
  parameter int PTEP_W  = 42,
  parameter int LOW_WM  = 2,
  parameter int HIGH_WM = 4,
  localparam int IDX_W  = $clog2(NPAGES),
  localparam int CNT_W  = $clog2(NPAGES + 1),
  localparam int TLB_W  = (NTLB > 1) ? $clog2(NTLB) : 1,
  localparam int PTE_W  = PPN_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req,
  input  logic [PPN_W-1:0]  alloc_ppn,
  input  logic [PTEP_W-1:0] alloc_ptep,
  output logic              alloc_ok,
  output logic [IDX_W-1:0]  alloc_page,
  input  logic              res_set,
  input  logic [IDX_W-1:0]  res_set_page,
  input  logic [TLB_W-1:0]  res_set_tlb,
  input  logic              res_clr,
  input  logic [IDX_W-1:0]  res_clr_page,
  input  logic [TLB_W-1:0]  res_clr_tlb,
  input  logic [NPAGES-1:0] page_dirty,
  output logic              pte_req,
  output logic              pte_we,
  output logic [PTEP_W-1:0] pte_addr,
  output logic [PTE_W-1:0]  pte_wdata,
  input  logic [PTE_W-1:0]  pte_rdata,
  input  logic              pte_ack,
  output logic              wb_req,
  output logic [IDX_W-1:0]  wb_page,
  output logic [PPN_W-1:0]  wb_ppn,
  input  logic              wb_done,
  output logic              drop_pulse,
  output logic [CNT_W-1:0]  free_count,
  output logic              no_victim
);

  localparam int VC_B = PPN_W;
  localparam int NC_B = PPN_W + 1;
  localparam int PU_B = PPN_W + 2;

  typedef enum logic [2:0] {IDLE, SCAN, LRD, LWR, WBK, DRP, ULK} st_t;
  st_t st;

  logic [PPN_W-1:0]  ppn_tab  [NPAGES];
  logic [PTEP_W-1:0] ptep_tab [NPAGES];
  logic [NTLB-1:0]   res_tab  [NPAGES];
  logic [IDX_W-1:0]  free_q   [NPAGES];
  logic [IDX_W-1:0]  ord_q    [NPAGES];

  logic [IDX_W-1:0] fhd, ftl, ohd, otl, vic;
  logic [CNT_W-1:0] fcnt, ocnt, scnt;
  logic [PTE_W-1:0] lock_val;
  logic             nov, act;

  function automatic logic [IDX_W-1:0] inc(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(NPAGES - 1)) ? '0 : p + 1'b1;
  endfunction

  wire [IDX_W-1:0] head      = ord_q[ohd];
  wire             head_busy = (|res_tab[head]) || (res_set && res_set_page == head);
  wire             do_alloc  = alloc_req && (fcnt != '0);
  wire             scan_go   = (st == SCAN) && !do_alloc;
  wire             take      = scan_go && !head_busy;
  wire             rot       = scan_go && head_busy;
  wire             pass_end  = rot && (CNT_W'(scnt + 1'b1) >= ocnt);
  wire             free_push = (st == ULK) && pte_ack;
  wire             ord_push  = do_alloc || rot;
  wire             ord_pop   = take || rot;
  wire [IDX_W-1:0] ord_in    = do_alloc ? free_q[fhd] : head;
  wire             below_lo  = fcnt < CNT_W'(LOW_WM);
  wire             below_hi  = fcnt < CNT_W'(HIGH_WM);
  wire             need      = below_lo || (act && below_hi);

  always_ff @(posedge clk) begin
    if (do_alloc) begin
      ppn_tab[free_q[fhd]]  <= alloc_ppn;
      ptep_tab[free_q[fhd]] <= alloc_ptep;
    end
    if (ord_push) ord_q[otl] <= ord_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPAGES; i++) begin
        free_q[i]  <= IDX_W'(i);
        res_tab[i] <= '0;
      end
    end else begin
      if (free_push) free_q[ftl] <= vic;
      if (res_set) res_tab[res_set_page][res_set_tlb] <= 1'b1;
      if (res_clr) res_tab[res_clr_page][res_clr_tlb] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt <= CNT_W'(NPAGES);
      fhd  <= '0;
      ftl  <= '0;
      ocnt <= '0;
      ohd  <= '0;
      otl  <= '0;
      act  <= 1'b0;
    end else begin
      fcnt <= fcnt + CNT_W'(free_push) - CNT_W'(do_alloc);
      if (do_alloc)  fhd <= inc(fhd);
      if (free_push) ftl <= inc(ftl);
      if (ord_pop)   ohd <= inc(ohd);
      if (ord_push)  otl <= inc(otl);
      ocnt <= ocnt + CNT_W'(ord_push) - CNT_W'(ord_pop);
      act  <= need;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= IDLE;
      vic      <= '0;
      scnt     <= '0;
      lock_val <= '0;
      nov      <= 1'b0;
    end else begin
      if (res_clr)       nov <= 1'b0;
      else if (pass_end) nov <= 1'b1;
      case (st)
        IDLE: if (need && !nov && ocnt != '0) begin
                st   <= SCAN;
                scnt <= '0;
              end
        SCAN: if (take) begin
                vic <= head;
                st  <= LRD;
              end else if (rot) begin
                scnt <= scnt + 1'b1;
                if (pass_end) st <= IDLE;
              end
        LRD:  if (pte_ack) begin
                lock_val <= pte_rdata;
                st       <= LWR;
              end
        LWR:  if (pte_ack) st <= page_dirty[vic] ? WBK : DRP;
        WBK:  if (wb_done) st <= ULK;
        DRP:  st <= ULK;
        ULK:  if (pte_ack) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  assign alloc_ok   = fcnt != '0;
  assign alloc_page = free_q[fhd];
  assign pte_req    = (st == LRD) || (st == LWR) || (st == ULK);
  assign pte_we     = (st == LWR) || (st == ULK);
  assign pte_addr   = ptep_tab[vic];
  assign pte_wdata  = (st == ULK) ? {1'b0, lock_val[NC_B], 1'b0, ppn_tab[vic]}
                                  : (lock_val | (PTE_W'(1) << PU_B));
  assign wb_req     = st == WBK;
  assign wb_page    = vic;
  assign wb_ppn     = ppn_tab[vic];
  assign drop_pulse = st == DRP;
  assign free_count = fcnt;
  assign no_victim  = nov;

  wire unused_vc = lock_val[VC_B];

endmodule

// File: rtl/evict_engine_chk.sv
module evict_engine_chk #(
  parameter int NPAGES  = 64,
  parameter int HIGH_WM = 4,
  parameter int CNT_W   = 7,
  parameter int IDX_W   = 6,
  parameter int PTEP_W  = 42
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pte_req,
  input logic              pte_we,
  input logic              pte_ack,
  input logic [PTEP_W-1:0] pte_addr,
  input logic              wb_req,
  input logic              wb_done,
  input logic [IDX_W-1:0]  wb_page,
  input logic              drop_pulse,
  input logic              no_victim,
  input logic [CNT_W-1:0]  free_count
);

  // R10
  pte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pte_req && !pte_ack |=> pte_req && $stable(pte_we) && $stable(pte_addr));

  // R10
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_done |=> wb_req && $stable(wb_page));

  // R7
  wb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> !pte_req && !drop_pulse);

  // R7
  drop_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse |=> !drop_pulse);

  // R9
  idle_nov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_victim |-> !wb_req && !drop_pulse);

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pte_req && !pte_we |-> free_count < CNT_W'(HIGH_WM));

  // R8
  free_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_count <= CNT_W'(NPAGES));

  // R8
  free_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_count == $past(free_count)) ||
    (free_count == $past(free_count) + 1'b1) ||
    (free_count == $past(free_count) - 1'b1));

endmodule

bind evict_engine evict_engine_chk #(
  .NPAGES(NPAGES), .HIGH_WM(HIGH_WM), .CNT_W(CNT_W), .IDX_W(IDX_W), .PTEP_W(PTEP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pte_req(pte_req), .pte_we(pte_we), .pte_ack(pte_ack),
  .pte_addr(pte_addr), .wb_req(wb_req), .wb_done(wb_done), .wb_page(wb_page),
  .drop_pulse(drop_pulse), .no_victim(no_victim), .free_count(free_count)
);

// File: tb/tb_evict_engine.sv
module tb_evict_engine;
  localparam int NP = 64;
  localparam int NT = 4;

  logic clk = 0;
  logic rst_n = 0;
  always #4 clk = ~clk;

  logic        alloc_req = 0;
  logic [35:0] alloc_ppn = '0;
  logic [41:0] alloc_ptep = '0;
  logic        alloc_ok;
  logic [5:0]  alloc_page;
  logic        res_set = 0;
  logic [5:0]  res_set_page = '0;
  logic [1:0]  res_set_tlb = '0;
  logic        res_clr = 0;
  logic [5:0]  res_clr_page = '0;
  logic [1:0]  res_clr_tlb = '0;
  logic [63:0] page_dirty = 64'hAAAA_AAAA_AAAA_AAAA;
  logic        pte_req, pte_we;
  logic [41:0] pte_addr;
  logic [38:0] pte_wdata;
  logic [38:0] pte_rdata = '0;
  logic        pte_ack = 0;
  logic        wb_req;
  logic [5:0]  wb_page;
  logic [35:0] wb_ppn;
  logic        wb_done = 0;
  logic        drop_pulse;
  logic [6:0]  free_count;
  logic        no_victim;

  evict_engine dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .alloc_ppn(alloc_ppn), .alloc_ptep(alloc_ptep),
    .alloc_ok(alloc_ok), .alloc_page(alloc_page),
    .res_set(res_set), .res_set_page(res_set_page), .res_set_tlb(res_set_tlb),
    .res_clr(res_clr), .res_clr_page(res_clr_page), .res_clr_tlb(res_clr_tlb),
    .page_dirty(page_dirty),
    .pte_req(pte_req), .pte_we(pte_we), .pte_addr(pte_addr), .pte_wdata(pte_wdata),
    .pte_rdata(pte_rdata), .pte_ack(pte_ack),
    .wb_req(wb_req), .wb_page(wb_page), .wb_ppn(wb_ppn), .wb_done(wb_done),
    .drop_pulse(drop_pulse), .free_count(free_count), .no_victim(no_victim)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;

  bit          mapped  [NP];
  logic [3:0]  mres    [NP];
  logic [35:0] mppn    [NP];
  logic [41:0] mptep   [NP];
  logic [38:0] pte_mem [NP];
  int mfc = NP;
  int cur_vic = 0;
  int stage = 0;
  int pd = 0, wd = 0, pg = 0, last_pg = 0;
  bit wb_seen = 0, dropped = 0, last_unlock = 0, pend = 0;
  int vq[$];

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog expired", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // PTE memory and writeback responders with varying latency
  always @(posedge clk) begin
    if (!rst_n) begin
      pte_ack <= 0;
      wb_done <= 0;
      pend = 0; pd = 0; wd = 0; stage = 0; last_unlock = 0;
    end else begin
      if (pend && !pte_req) chk(0, "R10 request dropped before ack", 0, 1);
      if (pte_ack) begin
        pte_ack <= 0;
        if (last_unlock) begin
          last_unlock = 0;
          mfc++;
          mapped[cur_vic] = 0;
          vq.push_back(cur_vic);
        end
      end else if (pte_req) begin
        if (pd > 0) begin
          pd--;
          pend = 1;
        end else begin
          pend = 0;
          pd = $urandom % 3;
          pg = int'(pte_addr[5:0]);
          if (!pte_we) begin
            cur_vic = pg;
            chk(mapped[pg], "R2 victim frame mapped", mapped[pg], 1);
            chk(pte_addr == mptep[pg], "R2 PTE address", pte_addr, mptep[pg]);
            chk(mres[pg] == 0, "R5 victim TLB-resident", mres[pg], 0);
            chk(stage == 0, "R6 lock read order", stage, 0);
            pte_rdata <= pte_mem[pg];
            stage = 1; wb_seen = 0; dropped = 0;
          end else if (stage == 1) begin
            chk(pte_wdata == (pte_mem[pg] | 39'h40_0000_0000), "R6 lock write", pte_wdata,
                pte_mem[pg] | 39'h40_0000_0000);
            pte_mem[pg] = pte_wdata;
            stage = 2;
          end else begin
            chk(stage == 2, "R6 unlock order", stage, 2);
            chk(page_dirty[pg] ? wb_seen : dropped, "R7 data step before unlock",
                {wb_seen, dropped}, page_dirty[pg] ? 2 : 1);
            chk(pte_wdata == {1'b0, pte_mem[pg][37], 1'b0, mppn[pg]}, "R6 unlock write",
                pte_wdata, {1'b0, pte_mem[pg][37], 1'b0, mppn[pg]});
            pte_mem[pg] = pte_wdata;
            stage = 0;
            last_unlock = 1;
          end
          pte_ack <= 1;
        end
      end
      if (wb_done) wb_done <= 0;
      else if (wb_req) begin
        if (wd > 0) wd--;
        else begin
          wd = $urandom % 4;
          chk(int'(wb_page) == cur_vic, "R7 writeback frame", wb_page, cur_vic);
          chk(wb_ppn == mppn[cur_vic], "R2 writeback ppn", wb_ppn, mppn[cur_vic]);
          chk(page_dirty[cur_vic], "R7 writeback of clean frame", 0, 1);
          chk(stage == 2, "R7 writeback after lock", stage, 2);
          wb_seen = 1;
          wb_done <= 1;
        end
      end
      if (drop_pulse) begin
        chk(!page_dirty[cur_vic], "R7 drop of dirty frame", 1, 0);
        chk(stage == 2, "R7 drop after lock", stage, 2);
        dropped = 1;
      end
    end
  end

  // a: allocate; sp: -2 set residence on allocated frame, -1 none; st: TLB; cp/ct: clear
  task automatic cyc1(input bit a, input int sp, input int st, input int cp, input int ct);
    @(negedge clk);
    chk(int'(free_count) == mfc, "R8 free count", free_count, mfc);
    last_pg = -1;
    if (a) begin
      chk(alloc_ok == (mfc != 0), "R11 alloc_ok", alloc_ok, mfc != 0);
      alloc_req = 1;
      #1;
      if (alloc_ok) begin
        last_pg = int'(alloc_page);
        chk(!mapped[last_pg], "R8 popped frame still mapped", last_pg, -1);
        mapped[last_pg] = 1;
        mppn[last_pg]  = {4'($urandom), 32'($urandom)};
        mptep[last_pg] = {36'($urandom), 6'(last_pg)};
        alloc_ppn  = mppn[last_pg];
        alloc_ptep = mptep[last_pg];
        pte_mem[last_pg] = {1'b0, 1'($urandom), 1'b1, 36'(last_pg)};
        mfc--;
        if (sp == -2) begin
          res_set = 1;
          res_set_page = 6'(last_pg);
          res_set_tlb = 2'(st);
          mres[last_pg][st] = 1'b1;
        end
      end
    end
    if (sp >= 0) begin
      res_set = 1;
      res_set_page = 6'(sp);
      res_set_tlb = 2'(st);
      mres[sp][st] = 1'b1;
    end
    if (cp >= 0) begin
      res_clr = 1;
      res_clr_page = 6'(cp);
      res_clr_tlb = 2'(ct);
      mres[cp][ct] = 1'b0;
    end
    @(posedge clk);
    #1;
    alloc_req = 0;
    res_set = 0;
    res_clr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc1(0, -1, 0, -1, 0);
  endtask

  task automatic clear_all();
    for (int p = 0; p < NP; p++)
      for (int t = 0; t < NT; t++)
        if (mres[p][t]) cyc1(0, -1, 0, p, t);
  endtask

  initial begin
    for (int i = 0; i < NP; i++) begin
      mapped[i] = 0; mres[i] = '0; mppn[i] = '0; mptep[i] = '0; pte_mem[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(free_count == 7'd64, "R1 reset free count", free_count, 64);
    chk(alloc_ok == 1, "R1 reset alloc_ok", alloc_ok, 1);
    chk(!no_victim && !pte_req && !wb_req, "R1 reset idle", {no_victim, pte_req, wb_req}, 0);

    // R1 ascending pop order; frame 0 TLB-resident
    for (int i = 0; i < 62; i++) begin
      cyc1(1, (i == 0) ? -2 : -1, 0, -1, 0);
      chk(last_pg == i, "R1 pop order", last_pg, i);
    end
    idle(30);
    // R3 no reclaim at the low mark
    chk(vq.size() == 0 && !pte_req, "R3 reclaim at free=2", vq.size(), 0);
    cyc1(1, -1, 0, -1, 0);
    chk(last_pg == 62, "R1 pop order", last_pg, 62);
    idle(250);
    // R4 / R5: frame 0 skipped, then 1,2,3 in age order
    chk(vq.size() == 3, "R3 reclaim count", vq.size(), 3);
    if (vq.size() == 3) begin
      chk(vq[0] == 1, "R4 first victim", vq[0], 1);
      chk(vq[1] == 2, "R4 second victim", vq[1], 2);
      chk(vq[2] == 3, "R5 third victim skips resident", vq[2], 3);
    end
    chk(free_count == 7'd4, "R3 stop at high mark", free_count, 4);
    vq.delete();

    // every mapped frame TLB-held
    for (int p = 0; p < NP; p++)
      if (mapped[p] && mres[p] == 0) cyc1(0, p, p % NT, -1, 0);
    begin
      int exp_pg[4] = '{63, 1, 2, 3};
      for (int i = 0; i < 4; i++) begin
        cyc1(1, -2, 1, -1, 0);
        chk(last_pg == exp_pg[i], "R8 freed frames return at tail", last_pg, exp_pg[i]);
      end
    end
    idle(300);
    chk(no_victim == 1, "R9 no victim flagged", no_victim, 1);
    chk(vq.size() == 0, "R9 nothing reclaimed", vq.size(), 0);
    // R11 pop while empty
    cyc1(1, -1, 0, -1, 0);
    chk(last_pg == -1, "R11 pop on empty", last_pg, -1);
    idle(5);
    chk(free_count == 0, "R11 count unchanged", free_count, 0);

    // R9 retry on clear
    cyc1(0, -1, 0, 10, 10 % NT);
    idle(300);
    chk(vq.size() == 1 && vq[0] == 10, "R9 retry victim", vq.size() == 1 ? vq[0] : -1, 10);
    chk(no_victim == 1 && free_count == 1, "R9 pass ends again", {no_victim, free_count}, {1'b1, 7'd1});
    vq.delete();
    cyc1(0, -1, 0, 20, 20 % NT);
    idle(300);
    chk(vq.size() == 1 && vq[0] == 20, "R9 second retry", vq.size() == 1 ? vq[0] : -1, 20);
    vq.delete();
    cyc1(1, -1, 0, -1, 0);
    chk(last_pg == 10, "R8 freed frame order", last_pg, 10);
    clear_all();
    idle(400);
    chk(free_count == 7'd4, "R3 refill to high mark", free_count, 4);
    chk(no_victim == 0, "R9 cleared by residence clear", no_victim, 0);
    vq.delete();

    // random phase: allocation pops racing frame returns
    for (int i = 0; i < 4000; i++) begin
      bit a = ($urandom % 3) == 0;
      int sp = (($urandom % 2) == 0) ? -2 : -1;
      int p = $urandom % NP;
      int t = $urandom % NT;
      int cp = mres[p][t] ? p : -1;
      cyc1(a && alloc_ok, sp, $urandom % NT, cp, t);
    end
    clear_all();
    idle(600);
    chk(free_count >= 7'd4, "R3 final refill", free_count, 4);
    chk(no_victim == 0, "R9 final state", no_victim, 0);
    chk(int'(free_count) == mfc, "R8 final count", free_count, mfc);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule